// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block holds the two error counters of a CAN node, one for receive errors and one for transmit errors, and derives the node's fault-confinement state from them. The bit stream processor drives it with single-cycle command pulses. These are a receive error, a dominant-bit-after-error-flag receive error, a transmit error, a receive success, a transmit success, and a pulse for each run of 11 consecutive recessive bits. The last of these is used only to recover from bus-off.

The block reports both counter values, an error-passive flag and a bus-off flag. The state machine has three states. `FC_ACTIVE` is the error-active state, `FC_PASSIVE` is error-passive and `FC_BUSOFF` is bus-off. It has these transitions:
- *go_passive*: `FC_ACTIVE` to `FC_PASSIVE` when either counter rises above 127.
- *go_active*: `FC_PASSIVE` to `FC_ACTIVE` when both counters are 127 or less.
- *go_busoff*: `FC_PASSIVE` (or `FC_ACTIVE`) to `FC_BUSOFF` when the transmit counter exceeds 255.
- *recover*: `FC_BUSOFF` to `FC_ACTIVE` after 128 recessive-run pulses, which also clears both counters.

The state is computed from the counters' next values, so the flags and the counters change on the same clock edge.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0, and both flags are 0 (error-active).
- R2: Outside bus-off, a transmit error adds 8 to the transmit counter. A transmit success subtracts 1 and never takes it below 0. If both arrive in the same cycle, the error wins.
- R3: Outside bus-off, a receive error adds 1 to the receive counter and a dominant-after-flag error adds 8, saturating at 255. If both arrive, the +8 is applied. Any receive error wins over a receive success in the same cycle.
- R4: Outside bus-off, a receive success when the receive counter is above 127 reloads it to 120. Otherwise it subtracts 1, never going below 0.
- R5: The error-passive flag is 1 exactly when either counter is above 127 and the transmit counter is 255 or less. It is valid in the same cycle as the counter values.
- R6: The node returns to error-active (both flags 0) as soon as both counters are 127 or less.
- R7: When the transmit counter exceeds 255 the bus-off flag is 1 and the error-passive flag is 0.
- R8: In bus-off, every error and success command is ignored and both counters hold.
- R9: In bus-off, the 128th recessive-run pulse clears both counters and returns the node to error-active. Recessive-run pulses received outside bus-off do not count toward the 128.
- R10: The error-passive and bus-off flags are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_err_i | input | 1 | Transmit error command pulse |
| tx_ok_i | input | 1 | Transmit success command pulse |
| rx_err_i | input | 1 | Receive error command pulse |
| rx_dom_err_i | input | 1 | Dominant-after-error-flag receive error pulse |
| rx_ok_i | input | 1 | Receive success command pulse |
| rec_seq_i | input | 1 | One run of 11 recessive bits seen |
| rec_cnt_o | output | 8 | Receive error counter |
| tec_cnt_o | output | 9 | Transmit error counter (reaches 256..263 in bus-off) |
| err_passive_o | output | 1 | Error-passive flag |
| bus_off_o | output | 1 | Bus-off flag |

## Verification
A directed phase tests each counter on its own first. It then sends simultaneous error and success pulses, which tells the priority rules apart. It drives the receive counter past 127 and then sends a success, which separates the reload from a plain decrement. It pushes the counter to 255, which separates saturation from wrap-around. It also covers exact threshold crossings at 127/128 and 255/256, every command pulsed during bus-off, and 127 versus 128 recessive-run pulses, some of them sent before bus-off was entered.

A long pseudo-random phase then sends mixed, overlapping command pulses. An arithmetic model in the bench predicts both counters and both flags, and they are compared every cycle.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [1:0] {
        FC_ACTIVE  = 2'd0,
        FC_PASSIVE = 2'd1,
        FC_BUSOFF  = 2'd2
    } fc_state_e;
endpackage

// File: rtl/fc_rx_counter.sv
module fc_rx_counter #(
    parameter int unsigned REC_W       = 8,
    parameter int unsigned STEP        = 1,
    parameter int unsigned DOM_STEP    = 8,
    parameter int unsigned PASSIVE_LIM = 127,
    parameter int unsigned RELOAD      = 120
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             clear_i,
    input  logic             err_i,
    input  logic             dom_err_i,
    input  logic             ok_i,
    output logic [REC_W-1:0] cnt_q,
    output logic [REC_W-1:0] cnt_d
);
    localparam logic [REC_W:0]   STEP_X   = (REC_W+1)'(STEP);
    localparam logic [REC_W:0]   DSTEP_X  = (REC_W+1)'(DOM_STEP);
    localparam logic [REC_W:0]   SAT_X    = {1'b0, {REC_W{1'b1}}};
    localparam logic [REC_W-1:0] PASS_V   = REC_W'(PASSIVE_LIM);
    localparam logic [REC_W-1:0] RELOAD_V = REC_W'(RELOAD);

    function automatic logic [REC_W-1:0] sat_add(input logic [REC_W-1:0] a,
                                                 input logic [REC_W:0]   s);
        logic [REC_W:0] sum;
        sum = {1'b0, a} + s;
        if (sum > SAT_X) return SAT_X[REC_W-1:0];
        return sum[REC_W-1:0];
    endfunction

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (!hold_i) begin
            if (dom_err_i)      cnt_d = sat_add(cnt_q, DSTEP_X);
            else if (err_i)     cnt_d = sat_add(cnt_q, STEP_X);
            else if (ok_i) begin
                if (cnt_q > PASS_V)      cnt_d = RELOAD_V;
                else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R4
    rx_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !clear_i && ok_i && !err_i && !dom_err_i && cnt_q > PASS_V)
        |=> cnt_q == RELOAD_V);

    // R3
    rx_never_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !clear_i && (err_i || dom_err_i)) |=> cnt_q > $past(cnt_q) || cnt_q == SAT_X[REC_W-1:0]);

    // R8
    rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fc_tx_counter.sv
module fc_tx_counter #(
    parameter int unsigned TEC_W = 9,
    parameter int unsigned STEP  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             clear_i,
    input  logic             err_i,
    input  logic             ok_i,
    output logic [TEC_W-1:0] cnt_q,
    output logic [TEC_W-1:0] cnt_d
);
    localparam logic [TEC_W-1:0] STEP_V = TEC_W'(STEP);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (!hold_i) begin
            if (err_i)                     cnt_d = cnt_q + STEP_V;
            else if (ok_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R2
    tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !clear_i && err_i) |=> cnt_q == $past(cnt_q) + STEP_V);

    // R2
    tx_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_i && !clear_i && !err_i && ok_i && cnt_q == '0) |=> cnt_q == '0);

    // R8
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !clear_i) |=> $stable(cnt_q));
endmodule

// File: rtl/fc_recovery.sv
module fc_recovery #(
    parameter int unsigned EVENTS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic seq_i,
    output logic done_o
);
    localparam int unsigned CW   = $clog2(EVENTS + 1);
    localparam logic [CW-1:0] LAST = CW'(EVENTS - 1);

    logic [CW-1:0] cnt_q;

    assign done_o = active_i && seq_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!active_i || done_o) cnt_q <= '0;
        else if (seq_i)             cnt_q <= cnt_q + 1'b1;
    end

    // R9
    recov_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> cnt_q == '0);
endmodule

// File: rtl/fc_state_fsm.sv
module fc_state_fsm
    import fc_pkg::*;
#(
    parameter int unsigned REC_W       = 8,
    parameter int unsigned TEC_W       = 9,
    parameter int unsigned PASSIVE_LIM = 127,
    parameter int unsigned BUSOFF_LIM  = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REC_W-1:0] rec_d_i,
    input  logic [TEC_W-1:0] tec_d_i,
    input  logic             recov_done_i,
    output logic             err_passive_o,
    output logic             bus_off_o
);
    localparam logic [REC_W-1:0] PASS_R = REC_W'(PASSIVE_LIM);
    localparam logic [TEC_W-1:0] PASS_T = TEC_W'(PASSIVE_LIM);
    localparam logic [TEC_W-1:0] BOFF_T = TEC_W'(BUSOFF_LIM);

    fc_state_e state_q, state_d;
    logic over_pass, over_boff;

    assign over_pass = (rec_d_i > PASS_R) || (tec_d_i > PASS_T);
    assign over_boff = (tec_d_i > BOFF_T);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_ACTIVE: begin
                if (over_boff)      state_d = FC_BUSOFF;
                else if (over_pass) state_d = FC_PASSIVE;
            end
            FC_PASSIVE: begin
                if (over_boff)       state_d = FC_BUSOFF;
                else if (!over_pass) state_d = FC_ACTIVE;
            end
            FC_BUSOFF: begin
                if (recov_done_i)    state_d = FC_ACTIVE;
            end
            default: state_d = FC_ACTIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FC_ACTIVE;
        else        state_q <= state_d;
    end

    always_comb begin
        err_passive_o = (state_q == FC_PASSIVE);
        bus_off_o     = (state_q == FC_BUSOFF);
    end

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_passive_o && bus_off_o));

    // R9
    busoff_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_off_o && !recov_done_i) |=> bus_off_o);
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf #(
    parameter int unsigned REC_W        = 8,
    parameter int unsigned TEC_W        = 9,
    parameter int unsigned TX_STEP      = 8,
    parameter int unsigned RX_STEP      = 1,
    parameter int unsigned RX_DOM_STEP  = 8,
    parameter int unsigned PASSIVE_LIM  = 127,
    parameter int unsigned BUSOFF_LIM   = 255,
    parameter int unsigned RX_RELOAD    = 120,
    parameter int unsigned RECOV_EVENTS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_err_i,
    input  logic             tx_ok_i,
    input  logic             rx_err_i,
    input  logic             rx_dom_err_i,
    input  logic             rx_ok_i,
    input  logic             rec_seq_i,
    output logic [REC_W-1:0] rec_cnt_o,
    output logic [TEC_W-1:0] tec_cnt_o,
    output logic             err_passive_o,
    output logic             bus_off_o
);
    localparam logic [REC_W-1:0] PASS_R = REC_W'(PASSIVE_LIM);
    localparam logic [TEC_W-1:0] PASS_T = TEC_W'(PASSIVE_LIM);
    localparam logic [TEC_W-1:0] BOFF_T = TEC_W'(BUSOFF_LIM);

    logic [REC_W-1:0] rec_d;
    logic [TEC_W-1:0] tec_d;
    logic             recov_done;

    fc_rx_counter #(
        .REC_W(REC_W), .STEP(RX_STEP), .DOM_STEP(RX_DOM_STEP),
        .PASSIVE_LIM(PASSIVE_LIM), .RELOAD(RX_RELOAD)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .hold_i(bus_off_o), .clear_i(recov_done),
        .err_i(rx_err_i), .dom_err_i(rx_dom_err_i), .ok_i(rx_ok_i),
        .cnt_q(rec_cnt_o), .cnt_d(rec_d)
    );

    fc_tx_counter #(
        .TEC_W(TEC_W), .STEP(TX_STEP)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .hold_i(bus_off_o), .clear_i(recov_done),
        .err_i(tx_err_i), .ok_i(tx_ok_i),
        .cnt_q(tec_cnt_o), .cnt_d(tec_d)
    );

    fc_recovery #(
        .EVENTS(RECOV_EVENTS)
    ) u_recov (
        .clk(clk), .rst_n(rst_n), .active_i(bus_off_o), .seq_i(rec_seq_i),
        .done_o(recov_done)
    );

    fc_state_fsm #(
        .REC_W(REC_W), .TEC_W(TEC_W),
        .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .rec_d_i(rec_d), .tec_d_i(tec_d),
        .recov_done_i(recov_done),
        .err_passive_o(err_passive_o), .bus_off_o(bus_off_o)
    );

    // R5
    passive_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_passive_o |-> ((rec_cnt_o > PASS_R) || (tec_cnt_o > PASS_T)) && (tec_cnt_o <= BOFF_T));

    // R6
    active_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_cnt_o <= PASS_R && tec_cnt_o <= PASS_T) |-> !err_passive_o && !bus_off_o);

    // R7
    busoff_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_cnt_o > BOFF_T) |-> bus_off_o && !err_passive_o);

    // R9
    recov_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        recov_done |=> rec_cnt_o == '0 && tec_cnt_o == '0 && !bus_off_o && !err_passive_o);
endmodule

// File: tb/test_can_fault_conf.sv
`timescale 1ns/1ps
module test_can_fault_conf;
    logic clk = 1'b0;
    logic rst_n;
    logic tx_err, tx_ok, rx_err, rx_dom, rx_ok, rseq;
    logic [7:0] rec;
    logic [8:0] tec;
    logic ep, bo;

    always #2.5 clk = ~clk;

    can_fault_conf i_can_fault_conf (
        .clk(clk), .rst_n(rst_n),
        .tx_err_i(tx_err), .tx_ok_i(tx_ok), .rx_err_i(rx_err),
        .rx_dom_err_i(rx_dom), .rx_ok_i(rx_ok), .rec_seq_i(rseq),
        .rec_cnt_o(rec), .tec_cnt_o(tec),
        .err_passive_o(ep), .bus_off_o(bo)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // bench model: 0 active, 1 passive, 2 bus-off
    int m_rec = 0, m_tec = 0, m_mode = 0, m_seq = 0;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare();
        check("R3 rec", int'(rec), m_rec);
        check("R2 tec", int'(tec), m_tec);
        check("R5 passive", int'(ep), (m_mode == 1) ? 1 : 0);
        check("R7 busoff", int'(bo), (m_mode == 2) ? 1 : 0);
    endtask

    task automatic model(bit te, bit to, bit re, bit rd, bit ro, bit sq);
        if (m_mode == 2) begin
            if (sq) begin
                if (m_seq == 127) begin
                    m_rec = 0; m_tec = 0; m_mode = 0; m_seq = 0;
                end else m_seq++;
            end
        end else begin
            if (te) m_tec += 8;
            else if (to && m_tec > 0) m_tec--;
            if (rd) m_rec = (m_rec + 8 > 255) ? 255 : m_rec + 8;
            else if (re) m_rec = (m_rec + 1 > 255) ? 255 : m_rec + 1;
            else if (ro) begin
                if (m_rec > 127) m_rec = 120;
                else if (m_rec > 0) m_rec--;
            end
            if (m_tec > 255) begin m_mode = 2; m_seq = 0; end
            else if (m_rec > 127 || m_tec > 127) m_mode = 1;
            else m_mode = 0;
        end
    endtask

    // called at a negedge; drives one cycle of commands, ends at next negedge
    task automatic cyc(bit te, bit to, bit re, bit rd, bit ro, bit sq);
        tx_err = te; tx_ok = to; rx_err = re; rx_dom = rd; rx_ok = ro; rseq = sq;
        model(te, to, re, rd, ro, sq);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tx_err = 0; tx_ok = 0; rx_err = 0; rx_dom = 0; rx_ok = 0; rseq = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 rec", int'(rec), 0);
        check("R1 tec", int'(tec), 0);
        check("R1 flags", int'({ep, bo}), 0);

        // R9: recessive runs outside bus-off must not pre-count
        for (int i = 0; i < 20; i++) cyc(0,0,0,0,0,1);

        // R2 transmit steps, floor, priority
        for (int i = 0; i < 3; i++) cyc(1,0,0,0,0,0);
        check("R2 three errors", int'(tec), 24);
        cyc(0,1,0,0,0,0); cyc(0,1,0,0,0,0);
        check("R2 decrement", int'(tec), 22);
        cyc(1,1,0,0,0,0);
        check("R2 error wins", int'(tec), 30);
        for (int i = 0; i < 32; i++) cyc(0,1,0,0,0,0);
        check("R2 floor at 0", int'(tec), 0);

        // R3 receive steps and priority
        cyc(0,0,1,0,0,0);
        check("R3 plus one", int'(rec), 1);
        cyc(0,0,0,1,0,0);
        check("R3 plus eight", int'(rec), 9);
        cyc(0,0,1,1,1,0);
        check("R3 dom wins", int'(rec), 17);

        // R5 / R4 / R6 thresholds
        for (int i = 0; i < 13; i++) cyc(0,0,0,1,0,0);
        check("R6 at 121 active", int'(ep), 0);
        for (int i = 0; i < 6; i++) cyc(0,0,1,0,0,0);
        check("R6 at 127 active", int'(ep), 0);
        cyc(0,0,1,0,0,0);
        check("R5 at 128 passive", int'(ep), 1);
        cyc(0,0,0,0,1,0);
        check("R4 reload", int'(rec), 120);
        check("R6 back to active", int'(ep), 0);
        for (int i = 0; i < 40; i++) cyc(0,0,0,1,0,0);
        check("R3 saturate", int'(rec), 255);

        // R7 bus-off entry at 256
        for (int i = 0; i < 31; i++) cyc(1,0,0,0,0,0);
        check("R5 tec 248 passive", int'(ep), 1);
        cyc(1,0,0,0,0,0);
        check("R7 tec 256", int'(tec), 256);
        check("R7 busoff", int'(bo), 1);
        check("R7 not passive", int'(ep), 0);

        // R8 ignored commands
        cyc(1,0,0,0,0,0); cyc(0,1,0,0,0,0); cyc(0,0,1,0,0,0);
        cyc(0,0,0,1,0,0); cyc(0,0,0,0,1,0); cyc(1,1,1,1,1,0);
        check("R8 tec held", int'(tec), 256);
        check("R8 rec held", int'(rec), 255);

        // R9 recovery count
        for (int i = 0; i < 127; i++) cyc(0,0,0,0,0,1);
        check("R9 still busoff at 127", int'(bo), 1);
        cyc(1,0,0,0,0,0);
        check("R9 gap keeps busoff", int'(bo), 1);
        cyc(0,0,0,0,0,1);
        check("R9 cleared rec", int'(rec), 0);
        check("R9 cleared tec", int'(tec), 0);
        check("R9 active", int'({ep, bo}), 0);

        // pseudo-random mixed sweep
        for (int n = 0; n < 40000; n++) begin
            cyc($urandom_range(0,5) == 0, $urandom_range(0,3) == 0,
                $urandom_range(0,5) == 0, $urandom_range(0,15) == 0,
                $urandom_range(0,2) == 0, $urandom_range(0,1) == 0);
        end

        finish_run();
    end
endmodule